// File: doc/BRIEF.md
# Posted Write Admission Controller

This block sits on the slave side of an AHB-to-far-bus bridge. For every write it sees, it decides in the first data-phase cycle what to do with it. It can retry the write, post it, or pass it to the local control registers. Once a long burst has been admitted, it can also stall that burst with wait states. The decision uses four inputs: a flag for a pending far-side read, a flag saying the DMA engine owns the request path, the occupancy of an outbound request queue, and the free space in a transmit data queue.

A direct write is admitted only when the whole burst fits. Each admitted burst pushes one request entry into the request queue, holding the start address, the word count and the byte strobes. It also pushes every data word into the transmit queue, in order. Both queues live inside the block. The far side drains them through simple pop ports.

Writes to the local register window are sorted into two groups. The command registers are locked out while the DMA engine owns the path. Writes to any other register complete at once and appear as a one-cycle register write strobe.

Top module: `post_write_gate`

## Requirements
- R1: A retry is given only in the cycle after a NONSEQ write address phase, never partway through a burst. It takes two cycles: hready_out low with hresp=2'b10, then hready_out high with hresp=2'b10.
- R2: While rd_pending is high at the address phase, every write to either window (sel_direct or sel_csr) is retried, and nothing enters either queue.
- R3: While dma_owns is high, direct writes are retried, and so are register writes whose word index haddr[5:2] is below 4. Register writes with a word index of 4 or more complete with OKAY. They raise csr_we for their data phase, with csr_idx set to the word index and csr_wdata set to hwdata.
- R4: A direct write is retried when the request queue already holds 4 entries.
- R5: A direct write is retried when the transmit queue (16 words) lacks room for the burst. The room needed depends on hburst: 3'b000 (SINGLE) needs 1 word, 3'b011 (INCR4) needs 4, 3'b101 (INCR8) needs 8, and 3'b001 (INCR) needs 8 whatever its real length.
- R6: An admitted SINGLE, INCR4, INCR8, or INCR burst of at most 8 words completes every beat with no wait state and OKAY.
- R7: An INCR burst longer than 8 words inserts wait states (hready_out low) while the transmit queue is full. It resumes in the cycle after a pop frees a slot.
- R8: INCR bursts of 1 to 255 words are carried whole. Their length is given on xfer_words, and the request entry's length field equals it.
- R9: The request entry is pushed on the first data beat and holds the start haddr, the word count (1, 4, 8, or xfer_words for INCR) and the wstrb value from the address phase. The data words leave the transmit queue in beat order.
- R10: After reset, hready_out is high, hresp is OKAY, csr_we is low, and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_direct | input | 1 | Select for the direct far-bus window |
| sel_csr | input | 1 | Select for the local register window |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write flag |
| hburst | input | 3 | AHB burst type |
| haddr | input | 32 | AHB address |
| hwdata | input | 32 | AHB write data |
| wstrb | input | 4 | Byte strobes of the burst, sampled at NONSEQ |
| xfer_words | input | 8 | Word count of an INCR burst (1 to 255) |
| rd_pending | input | 1 | A far-side read is outstanding |
| dma_owns | input | 1 | DMA engine owns the request path |
| hready_out | output | 1 | AHB ready |
| hresp | output | 2 | AHB response (00 OKAY, 10 RETRY) |
| csr_we | output | 1 | Register write strobe |
| csr_idx | output | 4 | Register word index |
| csr_wdata | output | 32 | Register write data |
| req_pop | input | 1 | Pop the request queue head |
| req_valid | output | 1 | Request queue not empty |
| req_addr | output | 32 | Head entry start address |
| req_len | output | 8 | Head entry word count |
| req_be | output | 4 | Head entry byte strobes |
| tx_pop | input | 1 | Pop the transmit queue head |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 32 | Head data word |

## Verification
A wrong occupancy count in either queue shows at the ports at the next NONSEQ write. That write gets a retry it should not get, or an OKAY it should not get, one cycle after its address phase. If the count runs high instead, a short burst that should flow freely picks up wait states. Any corruption of the captured address, count or strobes stays hidden until the queue head is popped. At that point the queue contents are compared word by word against a queue model kept in the bench. A stall that fails to release shows one cycle after the freeing pop.

// File: rtl/post_write_gate.sv
`timescale 1ns/1ps
module post_write_gate #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int BEW      = 4,
  parameter int RQD      = 4,
  parameter int TXD      = 16,
  parameter int CSR_AW   = 4,
  parameter int CMD_REGS = 4,
  parameter int LIM      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_direct,
  input  logic              sel_csr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hburst,
  input  logic [AW-1:0]     haddr,
  input  logic [DW-1:0]     hwdata,
  input  logic [BEW-1:0]    wstrb,
  input  logic [7:0]        xfer_words,
  input  logic              rd_pending,
  input  logic              dma_owns,
  output logic              hready_out,
  output logic [1:0]        hresp,
  output logic              csr_we,
  output logic [CSR_AW-1:0] csr_idx,
  output logic [DW-1:0]     csr_wdata,
  input  logic              req_pop,
  output logic              req_valid,
  output logic [AW-1:0]     req_addr,
  output logic [7:0]        req_len,
  output logic [BEW-1:0]    req_be,
  input  logic              tx_pop,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data
);
  localparam int RQW = $clog2(RQD + 1);
  localparam int TXW = $clog2(TXD + 1);
  localparam int RPW = (RQD > 1) ? $clog2(RQD) : 1;
  localparam int TPW = (TXD > 1) ? $clog2(TXD) : 1;
  localparam int SW  = TXW + 6;
  localparam logic [1:0] T_NSEQ = 2'b10, T_SEQ = 2'b11, T_BUSY = 2'b01;
  localparam logic [1:0] R_OK = 2'b00, R_RETRY = 2'b10;
  localparam logic [RQW-1:0]  RQ_FULL = RQW'(RQD);
  localparam logic [TXW-1:0]  TX_FULL = TXW'(TXD);
  localparam logic [SW-1:0]   TX_LIM  = SW'(TXD);
  localparam logic [RPW-1:0]  RQ_LAST = RPW'(RQD - 1);
  localparam logic [TPW-1:0]  TX_LAST = TPW'(TXD - 1);
  localparam logic [CSR_AW:0] CMD_LIM = (CSR_AW+1)'(CMD_REGS);
  localparam logic [7:0]      LONG    = 8'(LIM);

  logic rt1, rt2, dp_dir, dp_first, dp_long, dp_csr, live;
  logic [AW-1:0]     c_addr;
  logic [7:0]        c_len;
  logic [BEW-1:0]    c_be;
  logic [CSR_AW-1:0] c_idx;
  logic [RQW-1:0]    req_cnt;
  logic [TXW-1:0]    tx_cnt;
  logic [RPW-1:0]    rq_w, rq_r;
  logic [TPW-1:0]    tx_w, tx_r;
  logic [AW-1:0]     rq_addr_m [RQD];
  logic [7:0]        rq_len_m  [RQD];
  logic [BEW-1:0]    rq_be_m   [RQD];
  logic [DW-1:0]     tx_m      [TXD];
  logic [4:0]        need;
  logic [7:0]        a_len;

  wire tx_full  = tx_cnt == TX_FULL;
  assign hready_out = !rt1 && !(dp_dir && tx_full);
  assign hresp      = (rt1 || rt2) ? R_RETRY : R_OK;

  wire tx_push  = dp_dir && !tx_full;
  wire req_push = tx_push && dp_first;
  wire rq_pop_e = req_pop && req_cnt != '0;
  wire tx_pop_e = tx_pop && tx_cnt != '0;

  wire nseq  = hready_out && htrans == T_NSEQ && hwrite;
  wire dir_a = nseq && sel_direct;
  wire csr_a = nseq && sel_csr;
  wire [CSR_AW-1:0] a_idx = haddr[CSR_AW+1:2];
  wire a_cmd = {1'b0, a_idx} < CMD_LIM;
  wire dseq  = hready_out && htrans == T_SEQ && hwrite && sel_direct && live;

  always_comb begin
    case (hburst)
      3'b000:          begin need = 5'd1;  a_len = 8'd1;       end
      3'b001:          begin need = 5'd8;  a_len = xfer_words; end
      3'b010, 3'b011:  begin need = 5'd4;  a_len = 8'd4;       end
      3'b100, 3'b101:  begin need = 5'd8;  a_len = 8'd8;       end
      default:         begin need = 5'd16; a_len = 8'd16;      end
    endcase
  end

  wire [RQW:0] rq_after = {1'b0, req_cnt} + (RQW+1)'(req_push);
  wire [SW-1:0] tx_want = SW'(tx_cnt) + SW'(tx_push) + SW'(need);
  wire no_room = rq_after >= {1'b0, RQ_FULL} || tx_want > TX_LIM;
  wire retry = (rd_pending && (dir_a || csr_a)) ||
               (dma_owns && (dir_a || (csr_a && a_cmd))) ||
               (dir_a && no_room);
  wire admit = dir_a && !retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt1 <= 1'b0; rt2 <= 1'b0; dp_dir <= 1'b0; dp_first <= 1'b0;
      dp_long <= 1'b0; dp_csr <= 1'b0; live <= 1'b0;
      c_addr <= '0; c_len <= '0; c_be <= '0; c_idx <= '0;
    end else begin
      rt1 <= retry;
      rt2 <= rt1;
      if (hready_out) begin
        dp_dir   <= admit || dseq;
        dp_first <= admit;
        dp_csr   <= csr_a && !retry;
      end
      if (admit) begin
        live    <= 1'b1;
        c_addr  <= haddr;
        c_len   <= a_len;
        c_be    <= wstrb;
        dp_long <= hburst == 3'b001 && xfer_words > LONG;
      end else if (hready_out && htrans != T_SEQ && htrans != T_BUSY) begin
        live <= 1'b0;
      end
      if (csr_a && !retry) c_idx <= a_idx;
    end
  end

  assign csr_we    = dp_csr;
  assign csr_idx   = c_idx;
  assign csr_wdata = hwdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt <= '0; rq_w <= '0; rq_r <= '0;
      tx_cnt  <= '0; tx_w <= '0; tx_r <= '0;
    end else begin
      if (req_push) rq_w <= (rq_w == RQ_LAST) ? '0 : rq_w + 1'b1;
      if (rq_pop_e) rq_r <= (rq_r == RQ_LAST) ? '0 : rq_r + 1'b1;
      req_cnt <= req_cnt + RQW'(req_push) - RQW'(rq_pop_e);
      if (tx_push)  tx_w <= (tx_w == TX_LAST) ? '0 : tx_w + 1'b1;
      if (tx_pop_e) tx_r <= (tx_r == TX_LAST) ? '0 : tx_r + 1'b1;
      tx_cnt <= tx_cnt + TXW'(tx_push) - TXW'(tx_pop_e);
    end
  end

  always_ff @(posedge clk) begin
    if (req_push) begin
      rq_addr_m[rq_w] <= c_addr;
      rq_len_m[rq_w]  <= c_len;
      rq_be_m[rq_w]   <= c_be;
    end
    if (tx_push) tx_m[tx_w] <= hwdata;
  end

  assign req_valid = req_cnt != '0;
  assign req_addr  = rq_addr_m[rq_r];
  assign req_len   = rq_len_m[rq_r];
  assign req_be    = rq_be_m[rq_r];
  assign tx_valid  = tx_cnt != '0;
  assign tx_data   = tx_m[tx_r];

  p_retry_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_out && hresp == R_RETRY) |->
      $past(hready_out && htrans == T_NSEQ && hwrite && (sel_direct || sel_csr)));
  p_retry_second_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_out && hresp == R_RETRY) |=> (hready_out && hresp == R_RETRY));
  p_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_out && htrans == T_NSEQ && hwrite && (sel_direct || sel_csr) && rd_pending)
      |=> (!hready_out && hresp == R_RETRY && !csr_we));
  p_csr_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_out && htrans == T_NSEQ && hwrite && sel_csr && !rd_pending &&
     !(dma_owns && a_cmd)) |=> (csr_we && hresp == R_OK));
  p_req_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_out && htrans == T_NSEQ && hwrite && sel_direct && req_cnt == RQ_FULL)
      |=> hresp == R_RETRY);
  p_nowait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_dir && !dp_long) |-> hready_out);
  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_dir && tx_full && tx_pop) |=> hready_out);
endmodule

// File: tb/test_post_write_gate.sv
`timescale 1ns/1ps
module test_post_write_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_direct = 0, sel_csr = 0, hwrite = 0, rd_pending = 0, dma_owns = 0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hburst = 3'b000;
  logic [31:0] haddr = '0, hwdata = '0;
  logic [3:0] wstrb = '0;
  logic [7:0] xfer_words = 8'd1;
  logic req_pop = 0, tx_pop = 0;
  logic hready_out, csr_we, req_valid, tx_valid;
  logic [1:0] hresp;
  logic [3:0] csr_idx, req_be;
  logic [31:0] csr_wdata, req_addr, tx_data;
  logic [7:0] req_len;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] q_addr[$], q_tx[$];
  logic [7:0]  q_len[$];
  logic [3:0]  q_be[$];

  always #5 clk = ~clk;

  post_write_gate i_post_write_gate (
    .clk(clk), .rst_n(rst_n), .sel_direct(sel_direct), .sel_csr(sel_csr),
    .htrans(htrans), .hwrite(hwrite), .hburst(hburst), .haddr(haddr),
    .hwdata(hwdata), .wstrb(wstrb), .xfer_words(xfer_words),
    .rd_pending(rd_pending), .dma_owns(dma_owns), .hready_out(hready_out),
    .hresp(hresp), .csr_we(csr_we), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
    .req_pop(req_pop), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_be(req_be), .tx_pop(tx_pop), .tx_valid(tx_valid),
    .tx_data(tx_data));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int need_of(input logic [2:0] hb);
    case (hb)
      3'b000: return 1;
      3'b011: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] len_of(input logic [2:0] hb, input int n);
    case (hb)
      3'b000: return 8'd1;
      3'b011: return 8'd4;
      3'b101: return 8'd8;
      default: return 8'(n);
    endcase
  endfunction

  function automatic bit exp_retry(input bit dir, input logic [2:0] hb, input logic [3:0] idx);
    if (rd_pending) return 1;
    if (dma_owns && (dir || idx < 4)) return 1;
    if (dir && (q_addr.size() >= 4 || q_tx.size() + need_of(hb) > 16)) return 1;
    return 0;
  endfunction

  task automatic wr_dir(input logic [2:0] hb, input int n, input logic [31:0] addr, input logic [3:0] be);
    bit rt = exp_retry(1, hb, 4'd0);
    bit lng = (hb == 3'b001) && n > 8;
    int cnt = len_of(hb, 0) == 0 ? n : int'(len_of(hb, n));
    int stalls = 0;
    @(negedge clk);
    sel_direct = 1; hwrite = 1; htrans = 2'b10; hburst = hb; haddr = addr;
    wstrb = be; xfer_words = 8'(n);
    @(negedge clk);
    if (rt) begin
      sel_direct = 0; htrans = 2'b00;
      #1 chk(!hready_out && hresp == 2'b10, "R1 retry first cycle", {hready_out, hresp}, 3'b010);
      @(negedge clk);
      #1 chk(hready_out && hresp == 2'b10, "R1 retry second cycle", {hready_out, hresp}, 3'b110);
      return;
    end
    q_addr.push_back(addr); q_len.push_back(8'(cnt)); q_be.push_back(be);
    for (int i = 0; i < cnt; i++) begin
      hwdata = $urandom;
      htrans = (i < cnt - 1) ? 2'b11 : 2'b00;
      haddr = haddr + 4;
      if (i == cnt - 1) sel_direct = 0;
      #1;
      while (!hready_out) begin
        stalls++;
        chk(tx_valid && tx_data == q_tx[0], "R7 head during stall", tx_data, q_tx[0]);
        tx_pop = 1;
        void'(q_tx.pop_front());
        @(negedge clk);
        tx_pop = 0;
        #1;
      end
      chk(hresp == 2'b00, "R6 beat OKAY", {30'd0, hresp}, 0);
      q_tx.push_back(hwdata);
      @(negedge clk);
    end
    if (!lng) chk(stalls == 0, "R6 no wait states", stalls, 0);
    else if (cnt > 16) chk(stalls > 0, "R7 long burst stalled", stalls, 1);
  endtask

  task automatic wr_csr(input logic [3:0] idx);
    bit rt = exp_retry(0, 3'b000, idx);
    logic [31:0] d = $urandom;
    @(negedge clk);
    sel_csr = 1; hwrite = 1; htrans = 2'b10; hburst = 3'b000;
    haddr = {26'd0, idx, 2'b00};
    @(negedge clk);
    sel_csr = 0; htrans = 2'b00; hwdata = d;
    if (rt) begin
      #1 chk(!hready_out && hresp == 2'b10 && !csr_we, "R3 csr retry", {csr_we, hready_out, hresp}, 4'b0010);
      @(negedge clk);
      #1 chk(hready_out && hresp == 2'b10, "R1 csr retry second", {hready_out, hresp}, 3'b110);
      return;
    end
    #1 chk(csr_we && csr_idx == idx && csr_wdata == d && hready_out && hresp == 2'b00,
           "R3 csr write", {csr_we, csr_idx, 2'b00}, {1'b1, idx, 2'b00});
  endtask

  task automatic drain();
    @(negedge clk); #1;
    while (q_addr.size() > 0) begin
      chk(req_valid && req_addr == q_addr[0], "R9 req addr", req_addr, q_addr[0]);
      chk(req_len == q_len[0], "R8 req len", req_len, q_len[0]);
      chk(req_be == q_be[0], "R9 req strobes", req_be, q_be[0]);
      req_pop = 1;
      void'(q_addr.pop_front()); void'(q_len.pop_front()); void'(q_be.pop_front());
      @(negedge clk); req_pop = 0; #1;
    end
    chk(!req_valid, "R2 req empty after drain", req_valid, 0);
    while (q_tx.size() > 0) begin
      chk(tx_valid && tx_data == q_tx[0], "R9 tx data order", tx_data, q_tx[0]);
      tx_pop = 1;
      void'(q_tx.pop_front());
      @(negedge clk); tx_pop = 0; #1;
    end
    chk(!tx_valid, "R2 tx empty after drain", tx_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    #1 chk(hready_out && hresp == 2'b00 && !csr_we && !req_valid && !tx_valid,
           "R10 reset state", {hready_out, hresp, csr_we, req_valid, tx_valid}, 6'b100000);
    rst_n = 1;

    wr_dir(3'b000, 1, 32'h1000, 4'hF);
    wr_dir(3'b011, 4, 32'h2000, 4'h3);
    wr_dir(3'b101, 8, 32'h3000, 4'hC);
    drain();
    wr_dir(3'b001, 5, 32'h4000, 4'h1);
    wr_dir(3'b001, 1, 32'h4100, 4'h2);
    drain();

    rd_pending = 1;
    wr_dir(3'b000, 1, 32'h5000, 4'hF);
    wr_csr(4'd9);
    rd_pending = 0;
    drain();

    dma_owns = 1;
    wr_dir(3'b011, 4, 32'h6000, 4'hF);
    wr_csr(4'd1);
    wr_csr(4'd9);
    dma_owns = 0;
    wr_csr(4'd2);
    drain();

    for (int i = 0; i < 5; i++) wr_dir(3'b000, 1, 32'h7000 + 32'(i * 16), 4'h5);
    chk(q_addr.size() == 4, "R4 fifth single retried", q_addr.size(), 4);
    drain();

    wr_dir(3'b101, 8, 32'h8000, 4'hF);
    wr_dir(3'b011, 4, 32'h8100, 4'hF);
    wr_dir(3'b001, 2, 32'h8200, 4'hF);
    chk(q_tx.size() == 12, "R5 INCR counted as 8 words", q_tx.size(), 12);
    wr_dir(3'b000, 1, 32'h8300, 4'hF);
    wr_dir(3'b011, 4, 32'h8400, 4'hF);
    chk(q_tx.size() == 13, "R5 INCR4 short of room", q_tx.size(), 13);
    drain();

    wr_dir(3'b001, 20, 32'h9000, 4'hF);
    drain();
    wr_dir(3'b001, 255, 32'hA000, 4'hA);
    drain();

    for (int it = 0; it < 80; it++) begin
      int k = $urandom % 10;
      rd_pending = ($urandom % 8) == 0;
      dma_owns   = ($urandom % 6) == 0;
      case (k)
        0, 1: wr_csr(4'($urandom));
        2, 3: wr_dir(3'b000, 1, $urandom & 32'hFFFF_FFFC, 4'($urandom));
        4:    wr_dir(3'b011, 4, $urandom & 32'hFFFF_FFFC, 4'($urandom));
        5:    wr_dir(3'b101, 8, $urandom & 32'hFFFF_FFFC, 4'($urandom));
        6, 7: wr_dir(3'b001, 1 + ($urandom % 8), $urandom & 32'hFFFF_FFFC, 4'($urandom));
        8:    wr_dir(3'b001, 9 + ($urandom % 30), $urandom & 32'hFFFF_FFFC, 4'($urandom));
        default: drain();
      endcase
    end
    rd_pending = 0; dma_owns = 0;
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule